// File: doc/BRIEF.md
# Bus Access Wait-State Sequencer

This block decides how many clock states a single bus access lasts. It does not drive addresses or data. At the start of an access it takes the target space, the area number, the direction and a refresh flag. From these and a software-visible wait-control register it works out a base length, and it decides whether the external WAIT line is sampled. While the access runs it counts states and stretches the access for each asserted WAIT sample. In the final state it pulses a done strobe.

The space kinds are:
- external memory areas 0 to 7;
- DRAM column cycles;
- multiplexed address/data I/O;
- on-chip peripherals;
- on-chip memory.

Areas 0, 2 and 6 take a configurable long wait of 0 to 3 extra states. A refresh access ignores WAIT and instead inserts a configured count of 0 to 3 states.

Top module: `wseq_top`

## Requirements
- R1: The 16-bit control register reads 0xFFFF after reset. Bit 8+n is the wait-control bit of area n (n = 0..7), and bit 1 selects the DRAM write pitch. A write updates exactly those bits; bits 7:2 and bit 0 always read as 1 (all-zero write reads back 0x00FD).
- R2: An external access (req_space = 0) to area 1, 3, 4, 5 or 7 lasts 1 state with WAIT ignored when the area bit is 0. When the bit is 1 it lasts 2 states plus one per consecutive asserted WAIT sample.
- R3: An external access to area 0, 2 or 6 lasts 1 + long_wait states. WAIT samples are added only when the area bit is 1.
- R4: A DRAM column access (req_space = 1) lasts 1 state with WAIT ignored when its pitch bit is 0. When the pitch bit is 1 it lasts 2 states plus WAIT samples. The pitch bit is register bit 9 for reads and register bit 1 for writes.
- R5: A multiplexed I/O access (req_space = 2) lasts 4 states plus WAIT samples, whatever the register holds.
- R6: A peripheral access (req_space = 3) lasts 3 states and an on-chip memory access (req_space = 4, also codes 5 to 7) lasts 1 state. Neither samples WAIT.
- R7: A request with req_refresh = 1 lasts 2 + refresh_wait states whatever the space. WAIT is ignored.
- R8: WAIT is sampled at the edge ending the last base state and at each added state's edge. The first deasserted sample ends the access. state_count reads 0 when idle and runs 1, 2, …, N through an access of N states. cycle_done is high only in state N, and the count returns to 0 on the next edge.
- R9: A request is accepted only when state_count is 0. A request held high during an access does not disturb its count or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| long_wait | input | 2 | Long wait states for areas 0, 2, 6 |
| refresh_wait | input | 2 | Wait states inserted in a refresh access |
| req_valid | input | 1 | Access request |
| req_area | input | 3 | Target area number |
| req_space | input | 3 | Space kind: 0 ext, 1 DRAM, 2 mux I/O, 3 peripheral, 4+ on-chip memory |
| req_write | input | 1 | 1 = write access |
| req_refresh | input | 1 | Access is a refresh |
| ext_wait | input | 1 | External WAIT, 1 = stretch |
| cycle_done | output | 1 | High in the final state of an access |
| state_count | output | 8 | Current state number, 0 when idle |

## Verification
Every space kind is driven with WAIT asserted for a chosen number of states, from none up to several. A long assertion that covers base states too separates sampled paths from ignoring ones. It also shows that sampling starts no earlier than the last base state. Both settings of each area bit are tried in reads and writes, which tells the per-area bit, the DRAM read bit and the DRAM write bit apart. Sweeps of the long-wait and refresh-wait inputs, and held requests during busy accesses, cover the remaining lengths and the idle-only acceptance.

// File: rtl/wseq_pkg.sv
// Package: shared space codes and the per-access plan passed from the
// decoder to the state counter.
package wseq_pkg;
    localparam int LEN_W = 4;

    typedef enum logic [2:0] {
        SP_EXT    = 3'd0,
        SP_DRAM   = 3'd1,
        SP_MUXIO  = 3'd2,
        SP_PERIPH = 3'd3,
        SP_ONCHIP = 3'd4
    } space_e;

    typedef struct packed {
        logic [LEN_W-1:0] base_len;  // states before WAIT sampling ends the access
        logic             samp_wait; // WAIT sampled at the end of the base states
    } plan_t;
endpackage

// File: rtl/wseq_regs.sv
// Module: wseq_regs
// Holds the per-area wait-control bits and the DRAM write-pitch bit.
// Assumes a single-cycle write strobe; reserved bits are not stored.
module wseq_regs #(
    parameter int AREAS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [15:0]      reg_wdata,
    output logic [AREAS-1:0] area_bits,
    output logic             dram_wr_long,
    output logic [15:0]      reg_rdata
);
    localparam int AREA_LSB = 16 - AREAS;

    // One flop per area, each loaded from its own data bit.
    for (genvar g = 0; g < AREAS; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (!rst_n)
                area_bits[g] <= 1'b1;
            else if (reg_we)
                area_bits[g] <= reg_wdata[AREA_LSB+g];
        end
    end

    // DRAM write pitch flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dram_wr_long <= 1'b1;
        else if (reg_we)
            dram_wr_long <= reg_wdata[1];
    end

    // Readback: reserved positions are constant ones.
    always_comb begin
        reg_rdata = '1;
        reg_rdata[15:AREA_LSB] = area_bits;
        reg_rdata[1] = dram_wr_long;
    end
endmodule

// File: rtl/wseq_decode.sv
// Module: wseq_decode
// Purely combinational: turns a request and the configuration into a
// base length and a WAIT-sampling flag. Refresh overrides the space kind.
module wseq_decode
    import wseq_pkg::*;
#(
    parameter int AREAS = 8
) (
    input  logic [2:0]       req_area,
    input  logic [2:0]       req_space,
    input  logic             req_write,
    input  logic             req_refresh,
    input  logic [AREAS-1:0] area_bits,
    input  logic             dram_wr_long,
    input  logic [1:0]       long_wait,
    input  logic [1:0]       refresh_wait,
    output plan_t            plan
);
    localparam int DRAM_AREA = 1;

    logic area_bit;
    logic long_area;
    logic dram_bit;

    // Select the request's area bit and classify long-wait areas.
    always_comb begin
        area_bit  = area_bits[req_area];
        long_area = (req_area == 3'd0) || (req_area == 3'd2) || (req_area == 3'd6);
        dram_bit  = req_write ? dram_wr_long : area_bits[DRAM_AREA];
    end

    // Length and sampling decision per space kind.
    always_comb begin
        plan.base_len  = LEN_W'(1);
        plan.samp_wait = 1'b0;
        if (req_refresh) begin
            plan.base_len = LEN_W'(2) + LEN_W'(refresh_wait);
        end else begin
            unique case (req_space)
                SP_EXT: begin
                    if (long_area)
                        plan.base_len = LEN_W'(1) + LEN_W'(long_wait);
                    else
                        plan.base_len = area_bit ? LEN_W'(2) : LEN_W'(1);
                    plan.samp_wait = area_bit;
                end
                SP_DRAM: begin
                    plan.base_len  = dram_bit ? LEN_W'(2) : LEN_W'(1);
                    plan.samp_wait = dram_bit;
                end
                SP_MUXIO: begin
                    plan.base_len  = LEN_W'(4);
                    plan.samp_wait = 1'b1;
                end
                SP_PERIPH: plan.base_len = LEN_W'(3);
                default:   plan.base_len = LEN_W'(1);
            endcase
        end
    end
endmodule

// File: rtl/wseq_counter.sv
// Module: wseq_counter
// State counter: loads on an idle request, advances one per clock, ends
// when past the base length and WAIT is not (or not to be) sampled high.
// Assumes the plan is valid whenever req_valid is. Count saturates.
module wseq_counter
    import wseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  plan_t            plan,
    input  logic             ext_wait,
    output logic             cycle_done,
    output logic [CNT_W-1:0] state_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    plan_t held;
    logic  idle;

    assign idle = (state_count == '0);

    // Final-state detect: base reached and no stretching sample.
    always_comb begin
        cycle_done = !idle
                     && (state_count >= CNT_W'(held.base_len))
                     && !(held.samp_wait && ext_wait);
    end

    // Capture the plan when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (idle && req_valid)
            held <= plan;
    end

    // Advance, finish or start the state count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_count <= '0;
        else if (idle)
            state_count <= req_valid ? CNT_W'(1) : '0;
        else if (cycle_done)
            state_count <= '0;
        else if (state_count != CNT_MAX)
            state_count <= state_count + CNT_W'(1);
    end
endmodule

// File: rtl/wseq_top.sv
// Module: wseq_top
// Bus access wait-state sequencer. Joins register, decoder and counter.
// Assumes ext_wait is synchronous to clk.
module wseq_top
    import wseq_pkg::*;
#(
    parameter int AREAS = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [1:0]       long_wait,
    input  logic [1:0]       refresh_wait,
    input  logic             req_valid,
    input  logic [2:0]       req_area,
    input  logic [2:0]       req_space,
    input  logic             req_write,
    input  logic             req_refresh,
    input  logic             ext_wait,
    output logic             cycle_done,
    output logic [CNT_W-1:0] state_count
);
    logic [AREAS-1:0] area_bits;
    logic             dram_wr_long;
    plan_t            plan;

    wseq_regs #(.AREAS(AREAS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .area_bits(area_bits), .dram_wr_long(dram_wr_long), .reg_rdata(reg_rdata)
    );

    wseq_decode #(.AREAS(AREAS)) u_dec (
        .req_area(req_area), .req_space(req_space), .req_write(req_write),
        .req_refresh(req_refresh), .area_bits(area_bits),
        .dram_wr_long(dram_wr_long), .long_wait(long_wait),
        .refresh_wait(refresh_wait), .plan(plan)
    );

    wseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .plan(plan),
        .ext_wait(ext_wait), .cycle_done(cycle_done), .state_count(state_count)
    );
endmodule

// File: rtl/wseq_chk.sv
// Module: wseq_chk
// Property checker bound onto wseq_top; observes ports only.
module wseq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_space,
    input logic             req_refresh,
    input logic             cycle_done,
    input logic [CNT_W-1:0] state_count,
    input logic [15:0]      reg_rdata
);
    // R1
    reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7:2] == 6'h3F) && reg_rdata[0]);

    // R8
    done_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (state_count != '0));

    // R8
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (state_count == '0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_count != '0 && !cycle_done && state_count != '1)
        |=> (state_count == $past(state_count) + CNT_W'(1)));

    // R9
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_count == '0 && req_valid) |=> (state_count == CNT_W'(1)));

    // R6
    onchip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_count == '0 && req_valid && !req_refresh && req_space == 3'd4)
        |=> cycle_done);
endmodule

bind wseq_top wseq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_refresh(req_refresh), .cycle_done(cycle_done),
    .state_count(state_count), .reg_rdata(reg_rdata)
);

// File: tb/tb_wseq_top.sv
// Bench for wseq_top: directed corners plus seeded random accesses,
// each length compared with a model computed from the requirements.
module tb_wseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  long_wait = '0;
    logic [1:0]  refresh_wait = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_area = '0;
    logic [2:0]  req_space = '0;
    logic        req_write = 1'b0;
    logic        req_refresh = 1'b0;
    logic        ext_wait = 1'b0;
    logic        cycle_done;
    logic [7:0]  state_count;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] cfg = 16'hFFFF;

    always #10 clk = ~clk;

    wseq_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .long_wait(long_wait), .refresh_wait(refresh_wait),
        .req_valid(req_valid), .req_area(req_area), .req_space(req_space),
        .req_write(req_write), .req_refresh(req_refresh), .ext_wait(ext_wait),
        .cycle_done(cycle_done), .state_count(state_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Base length of an access per R2..R7.
    function automatic int base_len(input int sp, input int ar, input bit wr,
                                    input bit rf, input logic [15:0] c,
                                    input int lw, input int rw);
        bit b;
        if (rf) return 2 + rw;
        b = c[8+ar];
        case (sp)
            0: if (ar == 0 || ar == 2 || ar == 6) return 1 + lw;
               else return b ? 2 : 1;
            1: return (wr ? c[1] : c[9]) ? 2 : 1;
            2: return 4;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic bit samples(input int sp, input int ar, input bit wr,
                                   input bit rf, input logic [15:0] c);
        if (rf) return 1'b0;
        case (sp)
            0: return c[8+ar];
            1: return wr ? c[1] : c[9];
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        cfg = v;
    endtask

    // One access; WAIT held high from state 1 through state base+k-1.
    task automatic access(input string req, input int sp, input int ar,
                          input bit wr, input bit rf, input int k, input bit hold);
        int b, exp_n, n;
        bit ok;
        b = base_len(sp, ar, wr, rf, cfg, int'(long_wait), int'(refresh_wait));
        exp_n = samples(sp, ar, wr, rf, cfg) ? b + k : b;
        @(negedge clk);
        req_valid = 1'b1; req_space = 3'(sp); req_area = 3'(ar);
        req_write = wr; req_refresh = rf;
        n = 0; ok = 1'b1;
        for (int idx = 1; idx <= 64; idx++) begin
            @(negedge clk);
            req_valid = hold;
            ext_wait = (idx <= b + k - 1);
            #1;
            if (state_count != 8'(idx)) ok = 1'b0;
            if (cycle_done) begin n = idx; break; end
        end
        req_valid = 1'b0; ext_wait = 1'b0;
        check({req, " length"}, n, exp_n);
        check("R8 count sequence", int'(ok), 1);
        @(negedge clk);
        check("R8 idle after done", int'(state_count), 0);
    endtask

    initial begin : watchdog
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset value", int'(reg_rdata), 16'hFFFF);
        check("R8 reset idle", int'(state_count), 0);

        wr_reg(16'h0000);
        #1 check("R1 zero write readback", int'(reg_rdata), 16'h00FD);
        wr_reg(16'hA502);
        #1 check("R1 pattern readback", int'(reg_rdata), 16'hA5FF);

        // Directed corners
        wr_reg(16'h0000);
        access("R2 area3 fast ignores wait", 0, 3, 0, 0, 3, 0);
        access("R4 dram read short", 1, 1, 0, 0, 2, 0);
        access("R4 dram write short", 1, 1, 1, 0, 2, 0);
        long_wait = 2'd3;
        access("R3 area0 long no wait", 0, 0, 0, 0, 2, 0);
        access("R5 muxio regardless of bits", 2, 5, 0, 0, 2, 0);
        access("R6 periph ignores wait", 3, 0, 0, 0, 4, 0);
        access("R6 onchip ignores wait", 4, 0, 0, 0, 4, 0);
        wr_reg(16'hFFFF);
        access("R2 area7 slow wait", 0, 7, 0, 0, 3, 0);
        access("R3 area6 long plus wait", 0, 6, 0, 0, 2, 0);
        access("R4 dram read long", 1, 1, 0, 0, 1, 0);
        wr_reg(16'hFFFD);
        access("R4 dram write uses bit1", 1, 1, 1, 0, 2, 0);
        access("R4 dram read uses bit9", 1, 1, 0, 0, 2, 0);
        refresh_wait = 2'd3;
        access("R7 refresh ignores wait", 2, 1, 0, 1, 3, 0);
        access("R9 held request muxio", 2, 0, 0, 0, 5, 1);
        access("R9 held request area1", 0, 1, 1, 0, 0, 1);

        // Seeded random accesses
        for (int i = 0; i < 300; i++) begin
            if (i % 20 == 0) wr_reg(16'($urandom));
            long_wait = 2'($urandom);
            refresh_wait = 2'($urandom);
            access("R2-7 random", int'($urandom % 6), int'($urandom % 8),
                   1'($urandom), ($urandom % 8) == 0, int'($urandom % 5),
                   1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule